// File: doc/BRIEF.md
# Interleaved IQ Input Demultiplexer

This block receives one parallel data bus on which in-phase (I) and quadrature (Q) samples alternate, so the bus runs at twice the per-channel sample rate. A flag that travels with each word marks the I word, which is the first word of every pair. The block joins each I word to the Q word that follows it. It converts both words to the internal two's-complement format and routes them to the two DAC channels, A and B. It can swap the two channels and invert each channel on its own. A transmit-enable gate can force both channels to zero. All configuration is static control bits.

A sync input is captured once per pair. Depending on a phase-select bit, it is sampled either on the I word or on the Q word. When it is sampled on the Q word, it is held back and delivered with the pair whose I word arrives next. Downstream logic receives both channel words and the sync flag together, marked by a one-cycle valid strobe.

Top module: `iq_deinterleave`

## Requirements
- R1: Suppose a word is accepted with `in_vld`=1 and `in_flag`=1 (an I word), and the next accepted word has `in_flag`=0 (a Q word). Then `out_vld` is high for exactly one cycle, in the clock after the Q word. Between pairs, `out_a` and `out_b` keep their values.
- R2: A Q word that has no I word held is discarded and produces no `out_vld`. A second I word replaces the held one. Cycles with `in_vld`=0 change nothing.
- R3: With `cfg_swap`=0, the I word goes to `out_a` and the Q word goes to `out_b`. With `cfg_swap`=1, the I word goes to `out_b` and the Q word goes to `out_a`.
- R4: With `cfg_twos`=1, input words are already two's complement and pass unchanged. With `cfg_twos`=0, input words are offset binary and are converted by inverting bit DATA_W-1. For example, 0x2000 becomes 0x0000 and 0x0000 becomes 0x2000.
- R5: `cfg_inv_a`=1 inverts every bit of channel A, and `cfg_inv_b`=1 inverts every bit of channel B. Inversion is applied after routing.
- R6: When `cfg_tx_en`=0 at the Q word, both channel outputs of that pair are zero, while `out_vld` still pulses.
- R7: With `cfg_sync_on_q`=0, `out_sync` of a pair equals `in_sync` sampled on that pair's I word. `out_sync` is only ever high together with `out_vld`.
- R8: With `cfg_sync_on_q`=1, `in_sync` is sampled on the Q word that completes a pair. That value appears as `out_sync` of the next pair, and the pending value is cleared when that pair's I word is taken.
- R9: During and after reset, `out_a`, `out_b`, `out_vld` and `out_sync` are all zero and no I word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A word is present on `in_word` this cycle |
| in_word | input | DATA_W | Interleaved sample word |
| in_flag | input | 1 | High marks the I word of a pair |
| in_sync | input | 1 | Sync request, sampled on the selected phase |
| cfg_twos | input | 1 | 1: input is two's complement; 0: offset binary |
| cfg_swap | input | 1 | Exchange the channel routing |
| cfg_inv_a | input | 1 | Invert all bits of channel A |
| cfg_inv_b | input | 1 | Invert all bits of channel B |
| cfg_tx_en | input | 1 | 0 forces both channels to zero |
| cfg_sync_on_q | input | 1 | Sample sync on the Q word instead of the I word |
| out_a | output | DATA_W | Channel A sample, two's complement |
| out_b | output | DATA_W | Channel B sample, two's complement |
| out_vld | output | 1 | One-cycle strobe for a completed pair |
| out_sync | output | 1 | Sync flag delivered with the pair |

## Verification
The assertions check the timing properties on every cycle. They check that the strobe is one cycle wide and always follows a Q word, that the outputs hold between pairs, that sync is never seen without a strobe, that a gated pair is zero, and that the held I word stays unchanged. Whether the right words land on the right channel cannot be seen from a single cycle. The same holds for the offset-binary conversion, the inversion, the discarding of orphan Q words and the one-pair delay of a Q-phase sync. The bench shows these through its scenarios: it runs a reference model against random streams under changing configuration, plus directed cases.

// File: rtl/iqd_pkg.sv
`timescale 1ns/1ps
package iqd_pkg;
  typedef struct packed {
    logic twos;
    logic swap;
    logic inv_a;
    logic inv_b;
    logic tx_en;
    logic sync_on_q;
  } iqd_cfg_t;

  localparam int LANES = 2;
  localparam int LANE_I = 0;
  localparam int LANE_Q = 1;
endpackage

// File: rtl/iqd_fmt.sv
`timescale 1ns/1ps
module iqd_fmt #(
  parameter int DATA_W = 14
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              twos,
  output logic [DATA_W-1:0] conv
);
  localparam logic [DATA_W-1:0] SIGN_MASK = {1'b1, {(DATA_W-1){1'b0}}};

  // offset binary to two's complement: flip the sign bit
  always_comb begin
    if (twos) conv = raw;
    else      conv = raw ^ SIGN_MASK;
  end
endmodule

// File: rtl/iqd_pair.sv
`timescale 1ns/1ps
module iqd_pair #(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic              in_flag,
  input  logic [DATA_W-1:0] in_word,
  input  logic              in_sync,
  input  logic              sync_on_q,
  output logic              pair_vld,
  output logic [DATA_W-1:0] i_raw,
  output logic [DATA_W-1:0] q_raw,
  output logic              pair_sync
);
  logic              have_q;
  logic [DATA_W-1:0] hold_q;
  logic              pend_q;
  logic              psync_q;
  logic              take_i;
  logic              take_q;

  assign take_i = in_vld & in_flag;
  assign take_q = in_vld & ~in_flag & have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q  <= 1'b0;
      hold_q  <= '0;
      pend_q  <= 1'b0;
      psync_q <= 1'b0;
    end else if (take_i) begin
      hold_q <= in_word;
      have_q <= 1'b1;
      if (sync_on_q) begin
        psync_q <= pend_q;
        pend_q  <= 1'b0;
      end else begin
        psync_q <= in_sync;
      end
    end else if (take_q) begin
      have_q <= 1'b0;
      if (sync_on_q) pend_q <= in_sync;
    end
  end

  assign pair_vld  = take_q;
  assign i_raw     = hold_q;
  assign q_raw     = in_word;
  assign pair_sync = psync_q;

  // R2: the held I word only changes when a new I word is taken
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_vld && in_flag) |=> $stable(hold_q))
    else $error("held I word changed without an I word");

  // R2: a pair closes the held slot
  p_slot_closed_r2: assert property (@(posedge clk) disable iff (rst)
    (pair_vld && !(in_vld && in_flag)) |=> !have_q)
    else $error("slot still open after pair");
endmodule

// File: rtl/iqd_route.sv
`timescale 1ns/1ps
module iqd_route
  import iqd_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pair_vld,
  input  logic [DATA_W-1:0] i_raw,
  input  logic [DATA_W-1:0] q_raw,
  input  logic              pair_sync,
  input  iqd_cfg_t          cfg,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              out_vld,
  output logic              out_sync
);
  logic [DATA_W-1:0] lane_raw [LANES];
  logic [DATA_W-1:0] lane_fmt [LANES];
  logic [DATA_W-1:0] ch_a;
  logic [DATA_W-1:0] ch_b;
  logic [DATA_W-1:0] nxt_a;
  logic [DATA_W-1:0] nxt_b;

  assign lane_raw[LANE_I] = i_raw;
  assign lane_raw[LANE_Q] = q_raw;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iqd_fmt #(.DATA_W(DATA_W)) u_fmt (
      .raw  (lane_raw[g]),
      .twos (cfg.twos),
      .conv (lane_fmt[g])
    );
  end

  always_comb begin
    ch_a = cfg.swap ? lane_fmt[LANE_Q] : lane_fmt[LANE_I];
    ch_b = cfg.swap ? lane_fmt[LANE_I] : lane_fmt[LANE_Q];
    if (cfg.inv_a) ch_a = ~ch_a;
    if (cfg.inv_b) ch_b = ~ch_b;
    nxt_a = cfg.tx_en ? ch_a : '0;
    nxt_b = cfg.tx_en ? ch_b : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a    <= '0;
      out_b    <= '0;
      out_vld  <= 1'b0;
      out_sync <= 1'b0;
    end else begin
      out_vld  <= pair_vld;
      out_sync <= pair_vld & pair_sync;
      if (pair_vld) begin
        out_a <= nxt_a;
        out_b <= nxt_b;
      end
    end
  end

  // R6: a pair completed with transmit disabled carries zeros
  p_tx_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (pair_vld && !cfg.tx_en) |=> (out_a == '0 && out_b == '0))
    else $error("gated pair not zero");

  // R1: outputs hold between pairs
  p_hold_out_r1: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_a) && $stable(out_b)))
    else $error("outputs moved without a pair");
endmodule

// File: rtl/iq_deinterleave.sv
`timescale 1ns/1ps
module iq_deinterleave
  import iqd_pkg::*;
#(
  parameter int DATA_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [DATA_W-1:0] in_word,
  input  logic              in_flag,
  input  logic              in_sync,
  input  logic              cfg_twos,
  input  logic              cfg_swap,
  input  logic              cfg_inv_a,
  input  logic              cfg_inv_b,
  input  logic              cfg_tx_en,
  input  logic              cfg_sync_on_q,
  output logic [DATA_W-1:0] out_a,
  output logic [DATA_W-1:0] out_b,
  output logic              out_vld,
  output logic              out_sync
);
  iqd_cfg_t          cfg;
  logic              pair_vld;
  logic [DATA_W-1:0] i_raw;
  logic [DATA_W-1:0] q_raw;
  logic              pair_sync;

  always_comb begin
    cfg.twos      = cfg_twos;
    cfg.swap      = cfg_swap;
    cfg.inv_a     = cfg_inv_a;
    cfg.inv_b     = cfg_inv_b;
    cfg.tx_en     = cfg_tx_en;
    cfg.sync_on_q = cfg_sync_on_q;
  end

  iqd_pair #(.DATA_W(DATA_W)) u_pair (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_flag   (in_flag),
    .in_word   (in_word),
    .in_sync   (in_sync),
    .sync_on_q (cfg_sync_on_q),
    .pair_vld  (pair_vld),
    .i_raw     (i_raw),
    .q_raw     (q_raw),
    .pair_sync (pair_sync)
  );

  iqd_route #(.DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst       (rst),
    .pair_vld  (pair_vld),
    .i_raw     (i_raw),
    .q_raw     (q_raw),
    .pair_sync (pair_sync),
    .cfg       (cfg),
    .out_a     (out_a),
    .out_b     (out_b),
    .out_vld   (out_vld),
    .out_sync  (out_sync)
  );

  // R1: strobe only after a Q word, and never two in a row
  p_vld_after_q_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld && !in_flag))
    else $error("strobe without a Q word");

  p_vld_single_r1: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld)
    else $error("strobe wider than one cycle");

  // R7: sync travels only with a strobe
  p_sync_with_vld_r7: assert property (@(posedge clk) disable iff (rst)
    out_sync |-> out_vld)
    else $error("sync without strobe");
endmodule

// File: tb/iq_deinterleave_bench.sv
`timescale 1ns/1ps
module iq_deinterleave_bench;
  localparam int W = 14;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0, in_flag = 1'b0, in_sync = 1'b0;
  logic [W-1:0] in_word = '0;
  logic c_twos = 1'b1, c_swap = 1'b0, c_inv_a = 1'b0, c_inv_b = 1'b0;
  logic c_tx = 1'b1, c_sq = 1'b0;
  logic [W-1:0] out_a, out_b;
  logic out_vld, out_sync;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state
  bit m_have = 1'b0;
  logic [W-1:0] m_hold = '0;
  bit m_pend = 1'b0;
  bit m_psync = 1'b0;

  always #2.5 clk = ~clk;

  iq_deinterleave #(.DATA_W(W)) u_iq_deinterleave (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_word(in_word),
    .in_flag(in_flag), .in_sync(in_sync), .cfg_twos(c_twos),
    .cfg_swap(c_swap), .cfg_inv_a(c_inv_a), .cfg_inv_b(c_inv_b),
    .cfg_tx_en(c_tx), .cfg_sync_on_q(c_sq), .out_a(out_a),
    .out_b(out_b), .out_vld(out_vld), .out_sync(out_sync)
  );

  function automatic logic [W-1:0] to_int(input logic [W-1:0] w, input logic twos);
    logic [W-1:0] r;
    r = w;
    if (!twos) r[W-1] = ~w[W-1];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // drive one word, predict, and compare one clock later
  task automatic step(input logic v, input logic f, input logic [W-1:0] w, input logic s, input string req);
    bit e_vld;
    bit e_sync;
    logic [W-1:0] fi, fq, ea, eb;
    @(negedge clk);
    in_vld = v; in_flag = f; in_word = w; in_sync = s;
    e_vld = 1'b0; e_sync = 1'b0; ea = '0; eb = '0;
    if (v && f) begin
      m_hold = w; m_have = 1'b1;
      if (c_sq) begin m_psync = m_pend; m_pend = 1'b0; end
      else m_psync = s;
    end else if (v && !f && m_have) begin
      fi = to_int(m_hold, c_twos);
      fq = to_int(w, c_twos);
      ea = c_swap ? fq : fi;
      eb = c_swap ? fi : fq;
      if (c_inv_a) ea = ~ea;
      if (c_inv_b) eb = ~eb;
      if (!c_tx) begin ea = '0; eb = '0; end
      e_vld = 1'b1; e_sync = m_psync;
      m_have = 1'b0;
      if (c_sq) m_pend = s;
    end
    @(posedge clk);
    #1;
    chk(out_vld == e_vld, {req, " strobe"}, W'(out_vld), W'(e_vld));
    if (e_vld) begin
      chk(out_a == ea, {req, " out_a"}, out_a, ea);
      chk(out_b == eb, {req, " out_b"}, out_b, eb);
      chk(out_sync == e_sync, {req, " sync"}, W'(out_sync), W'(e_sync));
    end
  endtask

  task automatic set_cfg(input bit tw, input bit sw, input bit ia, input bit ib, input bit tx, input bit sq);
    @(negedge clk);
    c_twos = tw; c_swap = sw; c_inv_a = ia; c_inv_b = ib; c_tx = tx; c_sq = sq;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    chk(out_a == '0 && out_b == '0, "R9 data in reset", out_a, '0);
    chk(!out_vld && !out_sync, "R9 strobe in reset", W'({out_vld, out_sync}), '0);
    @(negedge clk); rst = 1'b0;
    step(1'b0, 1'b0, '0, 1'b0, "R9 idle");
    // R9: a Q word straight after reset finds no held I word
    step(1'b1, 1'b0, 14'h0123, 1'b0, "R9 no held I");

    // R1 and R3: plain pair, two's complement, no swap
    set_cfg(1, 0, 0, 0, 1, 0);
    step(1, 1, 14'h0AAA, 0, "R1 I word");
    step(1, 0, 14'h1555, 0, "R1 R3 pair");
    step(0, 0, 14'h3FFF, 0, "R1 hold");
    // R3: swapped
    set_cfg(1, 1, 0, 0, 1, 0);
    step(1, 1, 14'h0011, 0, "R3 I word");
    step(1, 0, 14'h0022, 0, "R3 swap pair");
    // R4: offset binary boundaries
    set_cfg(0, 0, 0, 0, 1, 0);
    step(1, 1, 14'h2000, 0, "R4 I word");
    step(1, 0, 14'h0000, 0, "R4 midscale and min");
    step(1, 1, 14'h3FFF, 0, "R4 I word");
    step(1, 0, 14'h1FFF, 0, "R4 max and below mid");
    // R5: per-channel inversion
    set_cfg(1, 0, 1, 0, 1, 0);
    step(1, 1, 14'h0F0F, 0, "R5 I word");
    step(1, 0, 14'h00FF, 0, "R5 invert A");
    set_cfg(1, 1, 0, 1, 1, 0);
    step(1, 1, 14'h0F0F, 0, "R5 I word");
    step(1, 0, 14'h00FF, 0, "R5 invert B swapped");
    // R6: transmit gate
    set_cfg(1, 0, 1, 1, 0, 0);
    step(1, 1, 14'h1234, 0, "R6 I word");
    step(1, 0, 14'h2345, 0, "R6 gated pair");
    // R2: orphan Q, repeated I, idle gaps
    set_cfg(1, 0, 0, 0, 1, 0);
    step(1, 0, 14'h0777, 0, "R2 orphan Q");
    step(1, 1, 14'h0100, 0, "R2 first I");
    step(1, 1, 14'h0200, 0, "R2 second I");
    step(0, 0, 14'h3333, 0, "R2 gap");
    step(1, 0, 14'h0300, 0, "R2 replaced I pair");
    // R7: sync on I phase
    step(1, 1, 14'h0001, 1, "R7 I with sync");
    step(1, 0, 14'h0002, 0, "R7 sync pair");
    step(1, 1, 14'h0003, 0, "R7 I no sync");
    step(1, 0, 14'h0004, 1, "R7 Q sync ignored");
    // R8: sync on Q phase, delivered one pair later
    set_cfg(1, 0, 0, 0, 1, 1);
    step(1, 1, 14'h0005, 1, "R8 I sync ignored");
    step(1, 0, 14'h0006, 1, "R8 Q sync sampled");
    step(1, 1, 14'h0007, 0, "R8 next I");
    step(1, 0, 14'h0008, 0, "R8 delivered pair");
    step(1, 1, 14'h0009, 0, "R8 I");
    step(1, 0, 14'h000A, 0, "R8 cleared pair");

    // random streams under changing configuration
    for (int seg = 0; seg < 20; seg++) begin
      set_cfg($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
              ($urandom % 4) != 0, $urandom % 2);
      for (int k = 0; k < 150; k++) begin
        bit f;
        f = (k % 2 == 0);
        if ($urandom % 8 == 0) f = $urandom % 2;
        step(($urandom % 8) != 0, f, W'($urandom), $urandom % 2, "R1 R3 R4 R5 R6 R7 R8 random");
      end
    end
    summary();
  end
endmodule